// File: doc/BRIEF.md
# Warp Lane Mask Stack

This block tracks which lanes of a 32-thread warp are allowed to commit results while the warp runs through nested conditional code. Every lane executes each instruction, and only lanes whose bit in the active mask is set keep their results. When the warp reaches a branch whose lanes disagree, the sequencer pulses the push strobe together with a per-lane predicate. The block saves the current mask on an internal stack and narrows the mask to the lanes whose predicate bit is set.

At the start of the other side of the branch, the sequencer pulses the else strobe. The mask then becomes the saved parent mask with the lanes of the first path removed. Lanes that were idle before the branch therefore stay idle. At the point where the paths rejoin, the pop strobe restores the saved parent mask. The stack holds up to eight nested levels. Misuse is recorded in two sticky flags and never corrupts the mask: a push onto a full stack sets one flag, and a pop or else with nothing saved sets the other.

A command takes effect at the clock edge that samples its strobe. One command is acted on per cycle.

Top module: `lane_mask_stack`

## Requirements
- R1: After reset, the active mask is all ones, the depth is 0, and both the overflow and underflow flags are 0.
- R2: A push with depth below 8 saves the current mask and sets the mask to the current mask AND the predicate (bit i is lane i). The depth rises by 1. All of this is visible after the sampling edge.
- R3: A push at depth 8 sets the sticky overflow flag and leaves the mask and the depth unchanged.
- R4: An else at depth above 0 sets the mask to the most recently saved mask AND NOT the current mask. This equals the parent mask with the predicate lanes removed. The depth is unchanged.
- R5: A pop at depth above 0 restores the most recently saved mask and lowers the depth by 1.
- R6: A pop or an else at depth 0 sets the sticky underflow flag and leaves the mask and the depth unchanged.
- R7: When several strobes are high in one cycle, only one is acted on, in this priority: push first, then else, then pop. The others are dropped.
- R8: In a cycle with no strobe high, the mask, the depth and both flags hold their values.
- R9: Saved masks come back in last-in, first-out order across all nested levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdPush | input | 1 | Divergent-branch strobe: save mask, narrow by predicate |
| cmdElse | input | 1 | Other-path strobe: switch to the complementary lanes |
| cmdPop | input | 1 | Reconvergence strobe: restore the saved mask |
| predIn | input | 32 | Per-lane branch predicate, used with push |
| activeMask | output | 32 | Lanes allowed to commit results |
| depth | output | 4 | Number of saved masks, 0 to 8 |
| overflowFlag | output | 1 | Sticky: a push was refused on a full stack |
| underflowFlag | output | 1 | Sticky: a pop or else was refused on an empty stack |

## Verification
The bench first fills all eight levels with distinct predicates and then tries a ninth push. A design that wrapped its write pointer would overwrite level 0 or change the mask, and the later unwinding would then return a wrong mask. It unwinds level by level to catch stack entries read out of order, and it issues an else under a partial parent mask. A design that complemented against all ones would wake lanes that were idle before the branch. It also issues pops and elses on an empty stack, where a careless design changes the mask or wraps the depth to 15, and it raises several strobes at once to expose a wrong priority or two commands acted on in one cycle.

// File: rtl/lms_pkg.sv
package lms_pkg;
  // Decoded strobes from control to datapath; at most one do* is set per cycle.
  typedef struct packed {
    logic doPush;
    logic doFlip;
    logic doPop;
    logic setOvf;
    logic setUdf;
  } stackCtl_t;
endpackage

// File: rtl/lms_ctrl.sv
module lms_ctrl
  import lms_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdPush,
  input  logic               cmdElse,
  input  logic               cmdPop,
  output stackCtl_t          ctl,
  output logic [DEPTH_W-1:0] depth,
  output logic               overflowFlag,
  output logic               underflowFlag
);
  localparam logic [DEPTH_W-1:0] FULL_LVL = DEPTH_W'(DEPTH);

  logic isFull, isEmpty;
  assign isFull  = (depth == FULL_LVL);
  assign isEmpty = (depth == '0);

  // Priority decode: push, then else, then pop (R7)
  always_comb begin
    ctl = '0;
    if (cmdPush) begin
      if (isFull) ctl.setOvf = 1'b1;
      else        ctl.doPush = 1'b1;
    end else if (cmdElse) begin
      if (isEmpty) ctl.setUdf = 1'b1;
      else         ctl.doFlip = 1'b1;
    end else if (cmdPop) begin
      if (isEmpty) ctl.setUdf = 1'b1;
      else         ctl.doPop  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth         <= '0;
      overflowFlag  <= 1'b0;
      underflowFlag <= 1'b0;
    end else begin
      if (ctl.doPush)      depth <= depth + 1'b1;
      else if (ctl.doPop)  depth <= depth - 1'b1;
      if (ctl.setOvf) overflowFlag  <= 1'b1;
      if (ctl.setUdf) underflowFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/lms_datapath.sv
module lms_datapath
  import lms_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int DEPTH_W = $clog2(DEPTH + 1),
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  stackCtl_t          ctl,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [LANES-1:0]   predIn,
  output logic [LANES-1:0]   activeMask
);
  logic [LANES-1:0] stackMem [DEPTH];
  logic [IDX_W-1:0] writeIdx, topIdx;
  logic [LANES-1:0] topMask;

  assign writeIdx = IDX_W'(depth);
  assign topIdx   = IDX_W'(depth - 1'b1);
  assign topMask  = stackMem[topIdx];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (ctl.doPush && (writeIdx == IDX_W'(e)))
        stackMem[e] <= activeMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           activeMask <= '1;
    else if (ctl.doPush) activeMask <= activeMask & predIn;
    else if (ctl.doFlip) activeMask <= topMask & ~activeMask;
    else if (ctl.doPop)  activeMask <= topMask;
  end
endmodule

// File: rtl/lane_mask_stack.sv
module lane_mask_stack
  import lms_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdPush,
  input  logic               cmdElse,
  input  logic               cmdPop,
  input  logic [LANES-1:0]   predIn,
  output logic [LANES-1:0]   activeMask,
  output logic [DEPTH_W-1:0] depth,
  output logic               overflowFlag,
  output logic               underflowFlag
);
  stackCtl_t ctl;

  lms_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdPush(cmdPush), .cmdElse(cmdElse), .cmdPop(cmdPop),
    .ctl(ctl), .depth(depth),
    .overflowFlag(overflowFlag), .underflowFlag(underflowFlag)
  );

  lms_datapath #(.LANES(LANES), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .depth(depth),
    .predIn(predIn), .activeMask(activeMask)
  );
endmodule

// File: rtl/lms_checker.sv
module lms_checker #(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmdPush,
  input logic               cmdElse,
  input logic               cmdPop,
  input logic [LANES-1:0]   predIn,
  input logic [LANES-1:0]   activeMask,
  input logic [DEPTH_W-1:0] depth,
  input logic               overflowFlag,
  input logic               underflowFlag
);
  localparam logic [DEPTH_W-1:0] FULL_LVL = DEPTH_W'(DEPTH);

  assert_push_narrows_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPush && depth != FULL_LVL) |=>
      (depth == $past(depth) + 1'b1) && (activeMask == ($past(activeMask) & $past(predIn))));

  assert_full_push_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPush && depth == FULL_LVL) |=> overflowFlag && $stable(depth) && $stable(activeMask));

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  assert_else_disjoint_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdElse && !cmdPush && depth != '0) |=>
      $stable(depth) && ((activeMask & $past(activeMask)) == '0));

  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdPop || cmdElse) && !cmdPush && depth == '0) |=>
      underflowFlag && $stable(activeMask) && (depth == '0));

  assert_underflow_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    underflowFlag |=> underflowFlag);

  assert_push_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPush && cmdPop && depth != FULL_LVL) |=> depth == $past(depth) + 1'b1);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdPush && !cmdElse && !cmdPop) |=> $stable(activeMask) && $stable(depth));

  always_comb begin
    if (rstN) assert_depth_bound_R9: assert (depth <= FULL_LVL);
  end
endmodule

bind lane_mask_stack lms_checker #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .cmdPush(cmdPush), .cmdElse(cmdElse), .cmdPop(cmdPop),
  .predIn(predIn), .activeMask(activeMask), .depth(depth),
  .overflowFlag(overflowFlag), .underflowFlag(underflowFlag)
);

// File: tb/lane_mask_stack_tb.sv
module lane_mask_stack_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdPush = 1'b0, cmdElse = 1'b0, cmdPop = 1'b0;
  logic [31:0] predIn = '0;
  logic [31:0] activeMask;
  logic [3:0]  depth;
  logic        overflowFlag, underflowFlag;

  always #2.5 clk = ~clk;

  lane_mask_stack u_dut (
    .clk(clk), .rstN(rstN), .cmdPush(cmdPush), .cmdElse(cmdElse), .cmdPop(cmdPop),
    .predIn(predIn), .activeMask(activeMask), .depth(depth),
    .overflowFlag(overflowFlag), .underflowFlag(underflowFlag)
  );

  typedef struct {
    logic [31:0] mask;
    int          dep;
    bit          ovf;
    bit          udf;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 0;

  // Reference state built from the requirements
  logic [31:0] mMask;
  logic [31:0] mStk [8];
  int          mDepth;
  bit          mOvf, mUdf;

  task automatic compareNow(input expItem_t e);
    nChecks++;
    if (activeMask !== e.mask || depth !== 4'(e.dep) ||
        overflowFlag !== e.ovf || underflowFlag !== e.udf) begin
      nFails++;
      $display("FAIL %s: mask=%h depth=%0d ovf=%0b udf=%0b expected mask=%h depth=%0d ovf=%0b udf=%0b",
               e.tag, activeMask, depth, overflowFlag, underflowFlag,
               e.mask, e.dep, e.ovf, e.udf);
    end
  endtask

  // Driver: apply one cycle of strobes, update the model, queue the expectation
  task automatic doCmd(input bit p, input bit el, input bit q,
                       input logic [31:0] pred, input string tag);
    expItem_t e;
    @(negedge clk);
    cmdPush = p; cmdElse = el; cmdPop = q; predIn = pred;
    @(posedge clk);
    #0.5;
    cmdPush = 0; cmdElse = 0; cmdPop = 0;
    if (p) begin
      if (mDepth == 8) mOvf = 1;
      else begin mStk[mDepth] = mMask; mMask = mMask & pred; mDepth++; end
    end else if (el) begin
      if (mDepth == 0) mUdf = 1;
      else mMask = mStk[mDepth-1] & ~mMask;
    end else if (q) begin
      if (mDepth == 0) mUdf = 1;
      else begin mDepth--; mMask = mStk[mDepth]; end
    end
    e.mask = mMask; e.dep = mDepth; e.ovf = mOvf; e.udf = mUdf; e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: compare each queued expectation at the following falling edge
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0) compareNow(expQ.pop_front());
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!doneFlag) begin
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    expItem_t r;
    mMask = '1; mDepth = 0; mOvf = 0; mUdf = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    r.mask = '1; r.dep = 0; r.ovf = 0; r.udf = 0; r.tag = "R1 reset";
    compareNow(r);

    // One if/else/endif
    doCmd(1, 0, 0, 32'h0000_FFFF, "R2 push narrows");
    doCmd(0, 1, 0, 32'h0,          "R4 else to complement");
    doCmd(0, 0, 0, 32'hFFFF_FFFF,  "R8 idle hold");
    doCmd(0, 0, 1, 32'h0,          "R5 pop restores");

    // Else under a partial parent mask
    doCmd(1, 0, 0, 32'h00FF_00FF, "R2 outer push");
    doCmd(1, 0, 0, 32'h0F0F_0F0F, "R2 inner push");
    doCmd(0, 1, 0, 32'h0,          "R4 else keeps idle lanes off");
    doCmd(0, 1, 0, 32'h0,          "R4 second else");
    doCmd(0, 0, 1, 32'h0,          "R9 pop inner");
    doCmd(0, 0, 1, 32'h0,          "R9 pop outer");

    // Fill all levels, then one push too many
    for (int i = 0; i < 8; i++)
      doCmd(1, 0, 0, ~(32'h1 << (i * 3)), "R2 fill level");
    doCmd(1, 0, 0, 32'h0, "R3 push when full");
    doCmd(0, 0, 0, 32'h0, "R3 overflow sticky");
    for (int i = 0; i < 8; i++)
      doCmd(0, 0, 1, 32'h0, "R9 unwind level");

    // Empty-stack misuse
    doCmd(0, 0, 1, 32'h0, "R6 pop when empty");
    doCmd(0, 1, 0, 32'h0, "R6 else when empty");
    doCmd(0, 0, 0, 32'h0, "R8 idle after flags");

    // Simultaneous strobes
    doCmd(1, 0, 1, 32'hAAAA_AAAA, "R7 push beats pop");
    doCmd(0, 1, 1, 32'h0,          "R7 else beats pop");
    doCmd(1, 1, 1, 32'h3333_3333, "R7 push beats all");
    doCmd(0, 0, 1, 32'h0,          "R5 pop after multi");
    doCmd(0, 0, 1, 32'h0,          "R5 pop to base");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL R8: %0d expectations left unchecked, expected 0", expQ.size());
    end
    doneFlag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule